// File: doc/BRIEF.md
# Modem Control and Status Registers

This block holds the two modem-line registers of a classic 8250-style serial port. A control register drives four active-low handshake outputs: data terminal ready, request to send, and two general-purpose outputs. The same register carries a loopback enable. A status register reports the present level of the four incoming modem lines: carrier detect, ring indicator, data set ready and clear to send. It also reports a sticky change flag for each line.

The host writes and reads the registers through a one-bit select, a write enable and a read strobe. Reading the status register with the strobe clears the change flags. A change that arrives in the same cycle sets its flag again, so no event is lost. External lines pass through a synchroniser before edge detection. In loopback the four control bits replace the external lines and the external pins are ignored. A single status-change output is high while any change flag is set, and can serve as an interrupt.

Top module: `modem_ctrl_status`

## Requirements
- R1: Writing the control register (sel_i = 0) stores wdata_i[4:0]. Reading it returns those five bits, and bits 7..5 always read as 0.
- R2: Control bit 0 drives dtr_n_o and bit 1 drives rts_n_o. A 1 drives the pin low, from the clock edge that takes the write.
- R3: Control bit 2 drives out1_n_o and bit 3 drives out2_n_o, with the same low-active polarity and timing as R2.
- R4: With control bit 4 set, the line states are CTS = control bit 1, DSR = control bit 0, RI = control bit 2 and DCD = control bit 3. These states are visible one edge after the write, and changes on the external modem pins have no effect.
- R5: Status bits 7..4 report the active state of DCD, RI, DSR and CTS, where 1 means the pin is low. Outside loopback, a pin change shows on the third clock edge after it.
- R6: Status bit 3 (DCD), bit 1 (DSR) and bit 0 (CTS) are set by any change of the matching line state and stay set until cleared.
- R7: Status bit 2 is set only when ri_n_i goes from low to high. A high-to-low change of ri_n_i leaves it unchanged.
- R8: A read strobe with sel_i = 1 clears status bits 3..0 at that edge. rdata_o shows the value before the clear, and a change landing on the same edge leaves its bit set.
- R9: stat_chg_o is 1 exactly when any of status bits 3..0 is 1.
- R10: After reset the control register is 0, all four outputs are high, and with idle (high) inputs the status register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register select: 0 control, 1 status |
| wr_en_i | input | 1 | Write enable (control register only) |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe; clears change bits when sel_i = 1 |
| rdata_o | output | 8 | Read data of the selected register |
| dtr_n_o | output | 1 | Data terminal ready, active low |
| rts_n_o | output | 1 | Request to send, active low |
| out1_n_o | output | 1 | General output 1, active low |
| out2_n_o | output | 1 | General output 2, active low |
| dcd_n_i | input | 1 | Carrier detect, active low |
| ri_n_i | input | 1 | Ring indicator, active low |
| dsr_n_i | input | 1 | Data set ready, active low |
| cts_n_i | input | 1 | Clear to send, active low |
| stat_chg_o | output | 1 | Any change bit set |

## Verification
The assertions assume that the host drives sel_i, wr_en_i and rd_en_i as clean synchronous signals. They also assume that a line does not toggle twice within the synchroniser window, since a double toggle inside the window merges into one observed change. The stimulus changes external pins at most once per three-cycle window and writes control values one at a time. Every state transition is therefore visible to the bench model.

// File: rtl/modem_regs_pkg.sv
package modem_regs_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned CTRL_W = 5;
  localparam int unsigned LINE_N = 4;

  // control bit positions
  localparam int unsigned C_DTR  = 0;
  localparam int unsigned C_RTS  = 1;
  localparam int unsigned C_OUT1 = 2;
  localparam int unsigned C_OUT2 = 3;
  localparam int unsigned C_LOOP = 4;

  // line index, matches status bit order (state at +4, change at +0)
  localparam int unsigned L_CTS = 0;
  localparam int unsigned L_DSR = 1;
  localparam int unsigned L_RI  = 2;
  localparam int unsigned L_DCD = 3;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_STAT = 1'b1} reg_sel_e;
endpackage

// File: rtl/modem_in_sync.sv
module modem_in_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/modem_delta_bit.sv
module modem_delta_bit #(
  parameter bit TRAIL_ONLY = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic clr_i,
  output logic state_o,
  output logic delta_o
);
  logic state_q, delta_q, chg;

  generate
    if (TRAIL_ONLY) begin : g_trail
      // active state falling == pin rising
      assign chg = state_q & ~line_i;
    end else begin : g_any
      assign chg = state_q ^ line_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      delta_q <= 1'b0;
    end else begin
      state_q <= line_i;
      delta_q <= (delta_q & ~clr_i) | chg;
    end
  end

  assign state_o = state_q;
  assign delta_o = delta_q;

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (delta_q && !clr_i) |=> delta_q);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (line_i == state_q)) |=> !delta_q);

  generate
    if (TRAIL_ONLY) begin : g_chk_trail
      assert_lead_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!delta_q && !state_q && line_i) |=> !delta_q);
      assert_trail_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q && !line_i) |=> delta_q);
    end else begin : g_chk_any
      assert_change_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_i != state_q) |=> delta_q);
    end
  endgenerate
endmodule

// File: rtl/modem_ctrl_status.sv
module modem_ctrl_status
  import modem_regs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             rd_en_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             dtr_n_o,
  output logic             rts_n_o,
  output logic             out1_n_o,
  output logic             out2_n_o,
  input  logic             dcd_n_i,
  input  logic             ri_n_i,
  input  logic             dsr_n_i,
  input  logic             cts_n_i,
  output logic             stat_chg_o
);
  localparam int unsigned PAD_W = REG_W - CTRL_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [LINE_N-1:0] pin_n, pin_sync_n, loop_vec, lines, state, delta;
  logic              ctrl_wr, stat_clr;

  assign ctrl_wr  = wr_en_i && (sel_i == SEL_CTRL);
  assign stat_clr = rd_en_i && (sel_i == SEL_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  assign dtr_n_o  = ~ctrl_q[C_DTR];
  assign rts_n_o  = ~ctrl_q[C_RTS];
  assign out1_n_o = ~ctrl_q[C_OUT1];
  assign out2_n_o = ~ctrl_q[C_OUT2];

  assign pin_n[L_DCD] = dcd_n_i;
  assign pin_n[L_RI]  = ri_n_i;
  assign pin_n[L_DSR] = dsr_n_i;
  assign pin_n[L_CTS] = cts_n_i;

  modem_in_sync #(.W(LINE_N), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_n),
    .q_o    (pin_sync_n)
  );

  assign loop_vec[L_CTS] = ctrl_q[C_RTS];
  assign loop_vec[L_DSR] = ctrl_q[C_DTR];
  assign loop_vec[L_RI]  = ctrl_q[C_OUT1];
  assign loop_vec[L_DCD] = ctrl_q[C_OUT2];

  assign lines = ctrl_q[C_LOOP] ? loop_vec : ~pin_sync_n;

  for (genvar g = 0; g < int'(LINE_N); g++) begin : g_line
    modem_delta_bit #(.TRAIL_ONLY(g == int'(L_RI))) u_bit (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .line_i  (lines[g]),
      .clr_i   (stat_clr),
      .state_o (state[g]),
      .delta_o (delta[g])
    );
  end

  assign rdata_o    = (sel_i == SEL_CTRL) ? {{PAD_W{1'b0}}, ctrl_q} : {state, delta};
  assign stat_chg_o = |delta;

  assert_ctrl_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> (ctrl_q == $past(wdata_i[CTRL_W-1:0])));

  assert_dtr_rts_pins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> (dtr_n_o == !$past(wdata_i[C_DTR])) && (rts_n_o == !$past(wdata_i[C_RTS])));

  assert_out_pins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> (out1_n_o == !$past(wdata_i[C_OUT1])) && (out2_n_o == !$past(wdata_i[C_OUT2])));

  assert_loopback_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_q[C_LOOP]) |-> (state == $past(loop_vec)));

  assert_flag_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_chg_o) |-> $past(lines != state));
endmodule

// File: tb/tb_modem_ctrl_status.sv
module tb_modem_ctrl_status;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       dtr_n, rts_n, out1_n, out2_n, stat_chg;
  logic [3:0] pins_n = 4'hF;   // {dcd, ri, dsr, cts}

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [3:0] m_st = '0;
  logic [3:0] m_dl = '0;
  logic [4:0] m_ctrl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_ctrl_status dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata),
    .dtr_n_o(dtr_n), .rts_n_o(rts_n), .out1_n_o(out1_n), .out2_n_o(out2_n),
    .dcd_n_i(pins_n[3]), .ri_n_i(pins_n[2]), .dsr_n_i(pins_n[1]), .cts_n_i(pins_n[0]),
    .stat_chg_o(stat_chg)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] loop_of(logic [4:0] c);
    return {c[3], c[2], c[0], c[1]};
  endfunction

  task automatic model_to(logic [3:0] ns);
    logic [3:0] chg;
    chg = {ns[3] ^ m_st[3], m_st[2] & ~ns[2], ns[1] ^ m_st[1], ns[0] ^ m_st[0]};
    m_dl = m_dl | chg;
    m_st = ns;
  endtask

  task automatic check_status(string req);
    sel = 1'b1;
    #1;
    check(req, rdata, {m_st, m_dl});
    check("R9", {7'd0, stat_chg}, {7'd0, |m_dl});
  endtask

  task automatic read_clear();
    sel = 1'b1; rd_en = 1'b1;
    #1;
    check("R8 pre-clear value", rdata, {m_st, m_dl});
    step();
    rd_en = 1'b0;
    m_dl = '0;
    check_status("R8 cleared");
  endtask

  task automatic write_ctrl(logic [7:0] v);
    sel = 1'b0; wr_en = 1'b1; wdata = v;
    step();
    wr_en = 1'b0;
    m_ctrl = v[4:0];
    check("R1 readback", rdata, {3'b000, v[4:0]});
    check("R2 dtr/rts", {6'd0, rts_n, dtr_n}, {6'd0, ~v[1], ~v[0]});
    check("R3 out1/out2", {6'd0, out2_n, out1_n}, {6'd0, ~v[3], ~v[2]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R10 reset state
    sel = 1'b0; #1;
    check("R10 ctrl", rdata, 8'h00);
    check("R10 pins", {4'd0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
    check_status("R10 status");

    // R1 R2 R3 R4: sweep all control values, reserved bits written as 1
    for (int v = 0; v < 32; v++) begin
      write_ctrl({3'b111, 5'(v)});
      step();
      model_to(m_ctrl[4] ? loop_of(m_ctrl) : 4'h0);
      check_status("R4 R6 loop state");
      if (v % 4 == 3) read_clear();
    end
    write_ctrl(8'h00);
    step();
    model_to(4'h0);
    read_clear();

    // R5 R6 R7: external pin sweep with occasional clears
    for (int i = 0; i < 48; i++) begin
      pins_n = 4'((i * 7 + 3) % 16);
      repeat (2) step();
      check_status("R5 before sync latency");
      step();
      model_to(~pins_n);
      check_status("R5 R6 R7 pin state");
      if (i % 3 == 2) read_clear();
    end
    read_clear();

    // R7 explicit ring edges
    pins_n = 4'hF;
    repeat (3) step();
    model_to(4'h0);
    read_clear();
    pins_n[2] = 1'b0;
    repeat (3) step();
    model_to(4'h0 | 4'b0100);
    check("R7 leading edge ignored", rdata, 8'h40);
    check("R9 no flag", {7'd0, stat_chg}, 8'h00);
    pins_n[2] = 1'b1;
    repeat (3) step();
    model_to(4'h0);
    check("R7 trailing edge", rdata, 8'h04);
    check("R9 flag", {7'd0, stat_chg}, 8'h01);
    read_clear();

    // R8 change landing on the clearing edge
    for (int k = 0; k < 4; k++) begin
      pins_n = 4'hF ^ 4'(1 << k);
      step(); step();
      sel = 1'b1; rd_en = 1'b1;
      step();
      rd_en = 1'b0;
      m_dl = '0;
      model_to(~pins_n);
      check_status("R8 same-edge change kept");
      pins_n = 4'hF;
      repeat (3) step();
      model_to(4'h0);
      read_clear();
    end

    // R4 external pins ignored in loopback
    write_ctrl(8'h1A);
    step();
    model_to(loop_of(5'h1A));
    read_clear();
    for (int p = 0; p < 16; p++) begin
      pins_n = 4'(p);
      repeat (3) step();
      check_status("R4 pins ignored");
    end
    pins_n = 4'hF;
    repeat (3) step();
    write_ctrl(8'h00);
    step();
    model_to(4'h0);
    check_status("R4 exit loopback");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule